// File: doc/BRIEF.md
# Paired-Register Coherent Read Latch

This block fronts a 256-byte internal buffer that a background poller keeps filled with a monitoring device's memory. A management agent reads the buffer one byte at a time, but most quantities in it are 16 bits wide and are split across an even/odd address pair. The poller may overwrite a field between the two byte reads, which would mix halves from two updates. To prevent this, each pair has a snapshot register and a latched flag. Reading the even byte captures the odd byte of the same pair in the same clock edge. A later read of the odd byte returns that captured copy, so both halves come from one update.

The poller's writes always land in the live buffer, whether or not a snapshot is held. An alarm output watches the live byte at offset 0x71, masked by an enable input. It never uses the snapshot, so a stale latched value can neither delay nor hide an alarm.

Top module: `coherent_pair_reader`

## Requirements
- R1: After reset, every one of the 256 offsets reads back 0x00, and `alarm` is 0.
- R2: A read strobe with an offset loads `rd_data` at the next rising edge. An even offset, or an odd offset whose pair is not latched, returns the live buffer byte last written there. A write stores `wr_data` at `wr_addr` on the edge where `wr_en` is high.
- R3: A read of even offset 2k returns live byte 2k. On the same edge it copies live byte 2k+1 into pair k's snapshot and sets pair k's latched flag.
- R4: A read of odd offset 2k+1 while pair k is latched returns the snapshot, even if byte 2k+1 has been rewritten since, and clears the flag. An immediate second read of 2k+1 returns the live byte.
- R5: A new read of even offset 2k refreshes pair k's snapshot with the current live odd byte, replacing any older snapshot.
- R6: Offsets 0x71 and 0x75 hold standalone bytes but obey the same latch rules: reading 0x70 or 0x74 latches them.
- R7: `alarm` equals the OR over the bits of (live byte 0x71 AND `alarm_mask`), registered once. It follows a write to 0x71 or a mask change one edge later, whatever the latch state of pair 0x38.
- R8: When a write and a read target the same odd offset on the same edge, the read returns the byte held before the write. When an even read coincides with a write to its odd partner, the snapshot also takes the pre-write byte.
- R9: `rd_data` holds its value on edges without a read strobe, even while the buffer byte it came from is rewritten.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Poller write strobe |
| wr_addr | input | 8 | Poller write offset |
| wr_data | input | 8 | Poller write byte |
| rd_en | input | 1 | Management read strobe |
| rd_addr | input | 8 | Management read offset; bit 0 selects the odd half of a pair |
| rd_data | output | 8 | Read result, valid from the edge after the strobe |
| alarm_mask | input | 8 | Per-bit enable for the alarm byte |
| alarm | output | 1 | Registered alarm from live byte 0x71 |

## Verification
A poller write and a management read can land on the same edge, and the sharpest case is a write to an odd byte together with a read of that byte or of its even partner. The bench drives both strobes in one cycle. For a plain odd read it expects the pre-write byte and then the new byte on the next read. For an even read it expects the snapshot to hold the pre-write byte and the byte after it to be live. The alarm is also judged while pair 0x38 is latched, so the alarm must show the newly written 0x71 while the odd read still returns the stale snapshot.

// File: rtl/cpr_pkg.sv
package cpr_pkg;
  localparam int unsigned WIN_AW    = 8;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned ALARM_OFS = 'h71;
endpackage

// File: rtl/cpr_rst_sync.sv
module cpr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_sync_n = out_q;
endmodule

// File: rtl/cpr_byte_store.sv
module cpr_byte_store #(
  parameter int unsigned AW        = 8,
  parameter int unsigned DW        = 8,
  parameter int unsigned ALARM_OFS = 'h71
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] live_byte,
  output logic [DW-1:0] odd_byte,
  output logic [DW-1:0] alarm_byte
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DEPTH-1:0] wr_hit;
  logic [DW-1:0]    mem [DEPTH];

  always_comb begin
    wr_hit = '0;
    if (wr_en) wr_hit[wr_addr] = 1'b1;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_byte
    logic [DW-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         q <= '0;
      else if (wr_hit[i]) q <= wr_data;
    end
    assign mem[i] = q;
  end

  assign live_byte  = mem[rd_addr];
  assign odd_byte   = mem[{rd_addr[AW-1:1], 1'b1}];
  assign alarm_byte = mem[ALARM_OFS[AW-1:0]];
endmodule

// File: rtl/cpr_snap_bank.sv
module cpr_snap_bank #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     rd_en,
  input  logic [AW-1:0]            rd_addr,
  input  logic [DW-1:0]            odd_live,
  output logic [DW-1:0]            snap_sel,
  output logic                     flag_sel,
  output logic [(1<<(AW-1))-1:0]   flags
);
  localparam int unsigned PAIRS = 1 << (AW - 1);
  localparam int unsigned PW    = AW - 1;

  logic [PW-1:0] pair_idx;
  logic          even_rd;
  logic          odd_rd;
  logic [DW-1:0] snap [PAIRS];

  assign pair_idx = rd_addr[AW-1:1];
  assign even_rd  = rd_en & ~rd_addr[0];
  assign odd_rd   = rd_en &  rd_addr[0];

  for (genvar i = 0; i < PAIRS; i++) begin : g_pair
    logic          hit;
    logic          load;
    logic          flag_d;
    logic          flag_q;
    logic [DW-1:0] snap_q;

    assign hit  = (pair_idx == PW'(i));
    assign load = even_rd & hit;

    always_comb begin
      flag_d = flag_q;
      if (load)             flag_d = 1'b1;
      else if (odd_rd & hit) flag_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= 1'b0;
      else        flag_q <= flag_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    snap_q <= '0;
      else if (load) snap_q <= odd_live;
    end

    assign snap[i]  = snap_q;
    assign flags[i] = flag_q;
  end

  assign snap_sel = snap[pair_idx];
  assign flag_sel = flags[pair_idx];
endmodule

// File: rtl/cpr_alarm.sv
module cpr_alarm #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] watch_byte,
  input  logic [DW-1:0] mask,
  output logic          alarm
);
  logic alarm_d;
  logic alarm_q;

  always_comb alarm_d = |(watch_byte & mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) alarm_q <= 1'b0;
    else        alarm_q <= alarm_d;
  end

  assign alarm = alarm_q;
endmodule

// File: rtl/coherent_pair_reader.sv
module coherent_pair_reader #(
  parameter int unsigned AW        = cpr_pkg::WIN_AW,
  parameter int unsigned DW        = cpr_pkg::BYTE_W,
  parameter int unsigned ALARM_OFS = cpr_pkg::ALARM_OFS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic [DW-1:0] alarm_mask,
  output logic          alarm
);
  localparam int unsigned PAIRS = 1 << (AW - 1);

  logic             rst_sync_n;
  logic [DW-1:0]    live_byte;
  logic [DW-1:0]    odd_live;
  logic [DW-1:0]    alarm_byte;
  logic [DW-1:0]    snap_sel;
  logic             flag_sel;
  logic [PAIRS-1:0] pair_flag;
  logic [DW-1:0]    rd_data_d;
  logic [DW-1:0]    rd_data_q;

  cpr_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  cpr_byte_store #(.AW(AW), .DW(DW), .ALARM_OFS(ALARM_OFS)) u_store (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .rd_addr    (rd_addr),
    .live_byte  (live_byte),
    .odd_byte   (odd_live),
    .alarm_byte (alarm_byte)
  );

  cpr_snap_bank #(.AW(AW), .DW(DW)) u_snap (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .odd_live (odd_live),
    .snap_sel (snap_sel),
    .flag_sel (flag_sel),
    .flags    (pair_flag)
  );

  cpr_alarm #(.DW(DW)) u_alarm (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .watch_byte (alarm_byte),
    .mask       (alarm_mask),
    .alarm      (alarm)
  );

  // Odd half of a latched pair comes from the snapshot; all else is live.
  always_comb begin
    if (rd_addr[0] && flag_sel) rd_data_d = snap_sel;
    else                        rd_data_d = live_byte;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  rd_data_q <= '0;
    else if (rd_en)   rd_data_q <= rd_data_d;
  end

  assign rd_data = rd_data_q;
endmodule

// File: rtl/cpr_checker.sv
module cpr_checker #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   rd_en,
  input logic [AW-1:0]          rd_addr,
  input logic [DW-1:0]          rd_data,
  input logic [DW-1:0]          live_byte,
  input logic [DW-1:0]          alarm_byte,
  input logic [DW-1:0]          alarm_mask,
  input logic                   alarm,
  input logic [(1<<(AW-1))-1:0] flags
);
  // R3
  even_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !rd_addr[0]) |=> rd_data == $past(live_byte));

  // R3
  even_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !rd_addr[0]) |=> flags[$past(rd_addr[AW-1:1])]);

  // R4
  odd_clears_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr[0]) |=> !flags[$past(rd_addr[AW-1:1])]);

  // R9
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));

  // R4
  flags_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(flags));

  // R7
  alarm_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> alarm == $past(|(alarm_byte & alarm_mask)));
endmodule

bind coherent_pair_reader cpr_checker #(.AW(AW), .DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .rd_en      (rd_en),
  .rd_addr    (rd_addr),
  .rd_data    (rd_data),
  .live_byte  (live_byte),
  .alarm_byte (alarm_byte),
  .alarm_mask (alarm_mask),
  .alarm      (alarm),
  .flags      (pair_flag)
);

// File: tb/coherent_pair_reader_bench.sv
`timescale 1ns/1ps
module coherent_pair_reader_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [7:0] wr_addr;
  logic [7:0] wr_data;
  logic       rd_en;
  logic [7:0] rd_addr;
  logic [7:0] rd_data;
  logic [7:0] alarm_mask;
  logic       alarm;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  coherent_pair_reader u_coherent_pair_reader (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .alarm_mask(alarm_mask), .alarm(alarm)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic wr_rd(input logic [7:0] wa, input logic [7:0] wd,
                       input logic [7:0] ra, output logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = wa; wr_data = wd;
    rd_en = 1'b1; rd_addr = ra;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    d = rd_data;
  endtask

  function automatic logic [7:0] pat(input int p, input int k);
    return 8'((p * 7 + k * 53 + 11) & 255);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
    wr_addr = '0; wr_data = '0; rd_addr = '0; alarm_mask = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state across the whole window
    chk("R1 alarm", int'(alarm), 0);
    for (int a = 0; a < 256; a++) begin
      rd(8'(a), d);
      chk("R1 read", int'(d), 0);
    end

    // Sweep every pair: live reads, latching, release, refresh
    for (int p = 0; p < 128; p++) begin
      logic [7:0] ea, oa;
      ea = 8'(2 * p); oa = 8'(2 * p + 1);
      wr(ea, pat(p, 0));
      wr(oa, pat(p, 1));
      rd(oa, d); chk("R2 odd unlatched live", int'(d), int'(pat(p, 1)));
      rd(ea, d); chk("R3 even live", int'(d), int'(pat(p, 0)));
      wr(oa, pat(p, 2));
      rd(oa, d); chk("R4 latched snapshot", int'(d), int'(pat(p, 1)));
      rd(oa, d); chk("R4 second read live", int'(d), int'(pat(p, 2)));
      rd(ea, d);
      wr(oa, pat(p, 3));
      rd(ea, d); chk("R5 even reread", int'(d), int'(pat(p, 0)));
      wr(oa, pat(p, 4));
      rd(oa, d); chk("R5 refreshed snapshot", int'(d), int'(pat(p, 3)));
      rd(oa, d); chk("R5 live after", int'(d), int'(pat(p, 4)));
    end

    // R6: standalone bytes at 0x71 and 0x75
    for (int s = 0; s < 2; s++) begin
      logic [7:0] ea, oa;
      ea = (s == 0) ? 8'h70 : 8'h74;
      oa = ea + 8'h01;
      wr(oa, 8'h3C);
      rd(ea, d);
      wr(oa, 8'hC3);
      rd(oa, d); chk("R6 standalone latched", int'(d), 'h3C);
      rd(oa, d); chk("R6 standalone live", int'(d), 'hC3);
    end

    // R7: alarm from live byte under several masks
    for (int m = 0; m < 6; m++) begin
      logic [7:0] mk;
      case (m)
        0: mk = 8'h00; 1: mk = 8'h01; 2: mk = 8'h80;
        3: mk = 8'hF0; 4: mk = 8'h0F; default: mk = 8'hFF;
      endcase
      for (int v = 0; v < 256; v += 17) begin
        @(negedge clk); alarm_mask = mk;
        wr(8'h71, 8'(v));
        @(negedge clk);
        chk("R7 alarm value", int'(alarm), int'(|(8'(v) & mk)));
      end
    end
    // R7: alarm ignores the held snapshot of 0x71
    wr(8'h71, 8'h00);
    @(negedge clk); alarm_mask = 8'h80;
    rd(8'h70, d);
    wr(8'h71, 8'h80);
    @(negedge clk);
    chk("R7 alarm while latched", int'(alarm), 1);
    rd(8'h71, d); chk("R7 snapshot still stale", int'(d), 0);
    // R7: one-edge latency after a write
    wr(8'h71, 8'h00);
    chk("R7 latency pre", int'(alarm), 1);
    @(negedge clk);
    chk("R7 latency post", int'(alarm), 0);

    // R8: same-edge write and read of an odd byte
    wr(8'h21, 8'h5A);
    wr_rd(8'h21, 8'hA5, 8'h21, d); chk("R8 odd pre-write", int'(d), 'h5A);
    rd(8'h21, d); chk("R8 odd post-write", int'(d), 'hA5);
    // R8: even read with write to odd partner on the same edge
    wr_rd(8'h21, 8'h77, 8'h20, d);
    rd(8'h21, d); chk("R8 snapshot pre-write", int'(d), 'hA5);
    rd(8'h21, d); chk("R8 live after", int'(d), 'h77);

    // R9: rd_data holds without a strobe while the source changes
    rd(8'h40, d);
    wr(8'h40, d ^ 8'hFF);
    repeat (3) @(negedge clk);
    chk("R9 hold", int'(rd_data), int'(d));

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule